// File: doc/BRIEF.md
# Two-Port Packet Switch with Interesting-Packet Counter

This block forwards packets from two input queues to two output queues. Each packet carries a routing bit that picks its output. It also carries a flag that marks it for counting. Producers push packets into the input queues through a valid/ready handshake. Consumers drain the output queues through a second valid/ready handshake. A running total of the flagged packets that have been forwarded is always visible on an output port.

All four queues are four entries deep. Packets are 16 bits wide. Bit 0 is the routing bit: 0 selects output 0 and 1 selects output 1. Bit 1 is the count flag.

Two packets can compete in one cycle in two ways:
- both head packets target the same output queue;
- both head packets are flagged, and the counter can take only one increment per cycle.

In both cases input 0 wins. Any packet that does not lose such a conflict is forwarded in that same cycle. The counter is 32 bits wide, clears on reset and wraps on overflow.

Top module: `pkt_switch_2x2`

## Requirements
- R1: A forwarded packet whose bit 0 is 0 is appended to output queue 0, and one whose bit 0 is 1 to output queue 1. Each output presents its packets in the order they were appended.
- R2: `pktCount` rises by exactly one for each forwarded packet whose bit 1 is set. It stays unchanged in a cycle where no flagged packet is forwarded.
- R3: A packet is forwarded only when its input queue is not empty and its target output queue holds fewer than 4 entries. An input's ready is high exactly when its queue holds fewer than 4 entries.
- R4: Suppose both input heads target the same output and input 0 can move. Then only the input 0 packet moves that cycle, and the input 1 packet follows in a later cycle.
- R5: Suppose both input heads are flagged, target different outputs, and both outputs have room. Then only the input 0 packet moves that cycle.
- R6: A head packet that can legally move and loses no conflict from R4 or R5 moves in that cycle. This holds for input 1 whenever input 0 cannot move, and both inputs move together when neither conflict applies.
- R7: A move takes effect in a single cycle. The packet leaves its input, appears at its output and is counted on the same clock edge.
- R8: After reset, all queues are empty: both output valids are low and both input readies are high. `pktCount` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| in0Valid | input | 1 | Input 0 offers a packet |
| in0Ready | output | 1 | Input 0 queue has room |
| in0Data | input | 16 | Input 0 packet |
| in1Valid | input | 1 | Input 1 offers a packet |
| in1Ready | output | 1 | Input 1 queue has room |
| in1Data | input | 16 | Input 1 packet |
| out0Valid | output | 1 | Output 0 queue holds a packet |
| out0Ready | input | 1 | Consumer takes the output 0 packet |
| out0Data | output | 16 | Oldest packet of output 0 |
| out1Valid | output | 1 | Output 1 queue holds a packet |
| out1Ready | input | 1 | Consumer takes the output 1 packet |
| out1Data | output | 16 | Oldest packet of output 1 |
| pktCount | output | 32 | Number of flagged packets forwarded |

## Verification
Two functions can fall into the same cycle:
- forwarding a packet from each input;
- counting a flagged packet.

They meet whenever both heads are present. The result is either a shared-output collision or a double-count collision.

Directed cases load one packet into each input in the same cycle while the outputs are stalled. The cases cover the same-target, flagged-pair and clean-parallel combinations. The checks then look at which output fills on which edge and what the counter reads. A long random phase with throttled consumers keeps outputs full or nearly full. A behavioural queue model then judges every cycle's valids, data, readies and count.

// File: rtl/pkt_sw_pkg.sv
package pkt_sw_pkg;

  // Strobes the control logic issues to the datapath each cycle.
  typedef struct packed {
    logic [1:0] move;     // input i forwards its head packet
    logic [1:0] pushOut;  // output k receives a packet
    logic [1:0] srcSel;   // output k source: 0 = input 0, 1 = input 1
    logic       countUp;  // counter takes one increment
  } swStrobeT;

endpackage

// File: rtl/sw_fifo.sv
module sw_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] fill;

  logic doPush, doPop;
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;

  assign empty   = (fill == '0);
  assign full    = (fill == CNT_W'(DEPTH));
  assign popData = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

endmodule

// File: rtl/sw_control.sv
module sw_control
  import pkt_sw_pkg::*;
(
  input  logic [1:0] headValid,
  input  logic [1:0] headDest,
  input  logic [1:0] headFlag,
  input  logic [1:0] outFull,
  output swStrobeT   strobe
);
  logic [1:0] canMove;
  logic       sameTarget;
  logic       bothFlagged;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      canMove[i] = headValid[i] && !outFull[headDest[i]];
    end
    sameTarget  = (headDest[0] == headDest[1]);
    bothFlagged = headFlag[0] && headFlag[1];

    strobe.move[0] = canMove[0];
    strobe.move[1] = canMove[1] && !(canMove[0] && (sameTarget || bothFlagged));

    for (int k = 0; k < 2; k++) begin
      strobe.pushOut[k] = (strobe.move[0] && (headDest[0] == 1'(k)))
                       || (strobe.move[1] && (headDest[1] == 1'(k)));
      strobe.srcSel[k]  = !(strobe.move[0] && (headDest[0] == 1'(k)));
    end

    strobe.countUp = (strobe.move[0] && headFlag[0]) || (strobe.move[1] && headFlag[1]);
  end

endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import pkt_sw_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 32,
  parameter int DEST_BIT = 0,
  parameter int FLAG_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       inValid,
  input  logic [WIDTH-1:0] inData [2],
  output logic [1:0]       inReady,
  input  logic [1:0]       outReady,
  output logic [1:0]       outValid,
  output logic [WIDTH-1:0] outData [2],
  output logic [CNT_W-1:0] count,
  input  swStrobeT         strobe,
  output logic [1:0]       headValid,
  output logic [1:0]       headDest,
  output logic [1:0]       headFlag,
  output logic [1:0]       outFull
);
  logic [WIDTH-1:0] head   [2];
  logic [WIDTH-1:0] outIn  [2];
  logic [1:0]       inEmpty, inFull, outEmpty;

  for (genvar i = 0; i < 2; i++) begin : g_port
    sw_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_inQ (
      .clk(clk), .rstN(rstN),
      .pushEn(inValid[i]), .pushData(inData[i]),
      .popEn(strobe.move[i]), .popData(head[i]),
      .empty(inEmpty[i]), .full(inFull[i])
    );

    assign outIn[i] = strobe.srcSel[i] ? head[1] : head[0];

    sw_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_outQ (
      .clk(clk), .rstN(rstN),
      .pushEn(strobe.pushOut[i]), .pushData(outIn[i]),
      .popEn(outReady[i]), .popData(outData[i]),
      .empty(outEmpty[i]), .full(outFull[i])
    );

    assign inReady[i]   = !inFull[i];
    assign outValid[i]  = !outEmpty[i];
    assign headValid[i] = !inEmpty[i];
    assign headDest[i]  = head[i][DEST_BIT];
    assign headFlag[i]  = head[i][FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.countUp) count <= count + 1'b1;
  end

endmodule

// File: rtl/pkt_switch_2x2.sv
module pkt_switch_2x2
  import pkt_sw_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 32,
  parameter int DEST_BIT = 0,
  parameter int FLAG_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             in0Valid,
  output logic             in0Ready,
  input  logic [WIDTH-1:0] in0Data,
  input  logic             in1Valid,
  output logic             in1Ready,
  input  logic [WIDTH-1:0] in1Data,
  output logic             out0Valid,
  input  logic             out0Ready,
  output logic [WIDTH-1:0] out0Data,
  output logic             out1Valid,
  input  logic             out1Ready,
  output logic [WIDTH-1:0] out1Data,
  output logic [CNT_W-1:0] pktCount
);
  swStrobeT         strobe;
  logic [1:0]       headValid, headDest, headFlag, outFull;
  logic [1:0]       inReadyV, outValidV;
  logic [WIDTH-1:0] inDataA  [2];
  logic [WIDTH-1:0] outDataA [2];

  assign inDataA[0] = in0Data;
  assign inDataA[1] = in1Data;

  sw_datapath #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .DEST_BIT(DEST_BIT), .FLAG_BIT(FLAG_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .inValid({in1Valid, in0Valid}), .inData(inDataA), .inReady(inReadyV),
    .outReady({out1Ready, out0Ready}), .outValid(outValidV), .outData(outDataA),
    .count(pktCount), .strobe(strobe),
    .headValid(headValid), .headDest(headDest), .headFlag(headFlag), .outFull(outFull)
  );

  sw_control u_ctl (
    .headValid(headValid), .headDest(headDest), .headFlag(headFlag),
    .outFull(outFull), .strobe(strobe)
  );

  assign in0Ready  = inReadyV[0];
  assign in1Ready  = inReadyV[1];
  assign out0Valid = outValidV[0];
  assign out1Valid = outValidV[1];
  assign out0Data  = outDataA[0];
  assign out1Data  = outDataA[1];

endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import pkt_sw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] pktCount,
  input swStrobeT         strobe,
  input logic [1:0]       headValid,
  input logic [1:0]       headDest,
  input logic [1:0]       headFlag,
  input logic [1:0]       outFull
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pktCount - $past(pktCount)) <= CNT_W'(1)); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.move[0] && headFlag[0]) && !(strobe.move[1] && headFlag[1])
      |=> $stable(pktCount)); // R2

  AST_MOVE0_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.move[0] |-> headValid[0] && !outFull[headDest[0]]); // R3

  AST_MOVE1_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.move[1] |-> headValid[1] && !outFull[headDest[1]]); // R3

  AST_NO_SHARED_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.move[0] && strobe.move[1] |-> headDest[0] != headDest[1]); // R4

  AST_NO_DOUBLE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.move[0] && strobe.move[1] |-> !(headFlag[0] && headFlag[1])); // R5

  AST_INPUT0_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    headValid[0] && !outFull[headDest[0]] |-> strobe.move[0]); // R6

  AST_INPUT1_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    headValid[1] && !outFull[headDest[1]] && !strobe.move[0] |-> strobe.move[1]); // R6

endmodule

bind pkt_switch_2x2 sw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .pktCount(pktCount), .strobe(strobe),
  .headValid(headValid), .headDest(headDest), .headFlag(headFlag), .outFull(outFull)
);

// File: tb/test_pkt_switch_2x2.sv
module test_pkt_switch_2x2;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        in0Valid = 1'b0, in1Valid = 1'b0;
  logic        out0Ready = 1'b0, out1Ready = 1'b0;
  logic [15:0] in0Data = '0, in1Data = '0;
  logic        in0Ready, in1Ready, out0Valid, out1Valid;
  logic [15:0] out0Data, out1Data;
  logic [31:0] pktCount;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit modelOn = 1'b0;

  always #10 clk = ~clk;

  pkt_switch_2x2 i_pkt_switch_2x2 (
    .clk(clk), .rstN(rstN),
    .in0Valid(in0Valid), .in0Ready(in0Ready), .in0Data(in0Data),
    .in1Valid(in1Valid), .in1Ready(in1Ready), .in1Data(in1Data),
    .out0Valid(out0Valid), .out0Ready(out0Ready), .out0Data(out0Data),
    .out1Valid(out1Valid), .out1Ready(out1Ready), .out1Data(out1Data),
    .pktCount(pktCount)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [15:0] qi0[$], qi1[$], qo0[$], qo1[$];
  logic [31:0] mCount;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qi0.delete(); qi1.delete(); qo0.delete(); qo1.delete();
      mCount = '0;
    end else begin
      logic [15:0] h0, h1;
      logic v0, v1, d0, d1, f0, f1, full0, full1, c0, c1, m0, m1;
      logic p0, p1, pop0, pop1;
      v0 = qi0.size() > 0; v1 = qi1.size() > 0;
      h0 = v0 ? qi0[0] : '0; h1 = v1 ? qi1[0] : '0;
      d0 = h0[0]; d1 = h1[0]; f0 = h0[1]; f1 = h1[1];
      full0 = qo0.size() >= 4; full1 = qo1.size() >= 4;
      c0 = v0 && !(d0 ? full1 : full0);
      c1 = v1 && !(d1 ? full1 : full0);
      m0 = c0;
      m1 = c1 && !(m0 && (d0 == d1 || (f0 && f1)));
      p0 = in0Valid && qi0.size() < 4;
      p1 = in1Valid && qi1.size() < 4;
      pop0 = out0Ready && qo0.size() > 0;
      pop1 = out1Ready && qo1.size() > 0;
      if (pop0) void'(qo0.pop_front());
      if (pop1) void'(qo1.pop_front());
      if (m0) begin if (d0) qo1.push_back(h0); else qo0.push_back(h0); end
      if (m1) begin if (d1) qo1.push_back(h1); else qo0.push_back(h1); end
      if (m0) void'(qi0.pop_front());
      if (m1) void'(qi1.pop_front());
      if (p0) qi0.push_back(in0Data);
      if (p1) qi1.push_back(in1Data);
      mCount = mCount + 32'(m0 && f0) + 32'(m1 && f1);
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      chk("R1", "out0Valid", 32'(out0Valid), 32'(qo0.size() > 0));
      chk("R1", "out1Valid", 32'(out1Valid), 32'(qo1.size() > 0));
      if (qo0.size() > 0) chk("R1", "out0Data", 32'(out0Data), 32'(qo0[0]));
      if (qo1.size() > 0) chk("R1", "out1Data", 32'(out1Data), 32'(qo1[0]));
      chk("R3", "in0Ready", 32'(in0Ready), 32'(qi0.size() < 4));
      chk("R3", "in1Ready", 32'(in1Ready), 32'(qi1.size() < 4));
      chk("R2", "pktCount", pktCount, mCount);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    in0Valid = 0; in1Valid = 0; out0Ready = 0; out1Ready = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk("R8", "out0Valid", 32'(out0Valid), 0);
    chk("R8", "out1Valid", 32'(out1Valid), 0);
    chk("R8", "in0Ready", 32'(in0Ready), 1);
    chk("R8", "in1Ready", 32'(in1Ready), 1);
    chk("R8", "pktCount", pktCount, 0);
  endtask

  // Drive one packet per input; returns at the negedge after the push edge.
  task automatic pushPair(input logic [15:0] a, input logic [15:0] b);
    in0Valid = 1; in0Data = a; in1Valid = 1; in1Data = b;
    @(negedge clk);
    in0Valid = 0; in1Valid = 0;
    chk("R7", "no early out0", 32'(out0Valid), 0);
    chk("R7", "no early out1", 32'(out1Valid), 0);
    chk("R7", "no early count", pktCount, 0);
  endtask

  initial begin
    modelOn = 1'b1;

    // Same-target collision
    doReset();
    pushPair(16'h1230, 16'h4560);
    @(negedge clk);
    chk("R4", "out0 gets input0", 32'(out0Data), 32'h1230);
    chk("R4", "out0Valid", 32'(out0Valid), 1);
    chk("R4", "out1 idle", 32'(out1Valid), 0);
    @(negedge clk);
    out0Ready = 1;
    @(negedge clk);
    out0Ready = 0;
    chk("R4", "input1 follows", 32'(out0Data), 32'h4560);

    // Double-count collision
    doReset();
    pushPair(16'hA002, 16'hB003);
    @(negedge clk);
    chk("R5", "out0Valid", 32'(out0Valid), 1);
    chk("R5", "out1 blocked", 32'(out1Valid), 0);
    chk("R5", "count one", pktCount, 1);
    @(negedge clk);
    chk("R5", "out1 later", 32'(out1Data), 32'hB003);
    chk("R5", "count two", pktCount, 2);

    // Parallel move, one flagged
    doReset();
    pushPair(16'hC000, 16'hD003);
    @(negedge clk);
    chk("R6", "out0Valid", 32'(out0Valid), 1);
    chk("R6", "out1Valid", 32'(out1Valid), 1);
    chk("R7", "count with move", pktCount, 1);
    chk("R1", "out1Data", 32'(out1Data), 32'hD003);

    // Input 0 blocked by full output 0, input 1 still moves
    doReset();
    for (int i = 0; i < 5; i++) begin
      in0Valid = 1; in0Data = 16'(16'h0100 + i * 16'h10);
      @(negedge clk);
    end
    in0Valid = 0;
    repeat (2) @(negedge clk);
    in0Valid = 1; in0Data = 16'h0E00; in1Valid = 1; in1Data = 16'h0F03;
    @(negedge clk);
    in0Valid = 0; in1Valid = 0;
    @(negedge clk);
    chk("R6", "input1 passes blocked input0", 32'(out1Valid), 1);
    chk("R3", "count from input1", pktCount, 1);

    // Random phase
    doReset();
    for (int n = 0; n < 4000; n++) begin
      in0Valid = ($urandom_range(0, 9) < 7);
      in1Valid = ($urandom_range(0, 9) < 7);
      in0Data = 16'($urandom);
      in1Data = 16'($urandom);
      out0Ready = ($urandom_range(0, 9) < 4);
      out1Ready = ($urandom_range(0, 9) < 4);
      @(negedge clk);
    end
    in0Valid = 0; in1Valid = 0; out0Ready = 1; out1Ready = 1;
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule